// File: doc/BRIEF.md
# Add/Subtract Unit with Stored Carry

This block is a two's complement adder/subtractor of parameterised width with a single stored carry flag. A ripple chain of full adders forms the result in the same cycle. Subtraction inverts every bit of the second operand and feeds a carry of 1 into the lowest bit. The outputs give the result with carry-out, unsigned overflow, signed overflow, negative and zero. These outputs are combinational and are valid in the same cycle as the operands.

Two control bits pick one of four variants of each operation. The first bit says whether the stored carry replaces the fixed low carry-in. The second says whether the carry-out is written into the flag on the next rising clock edge. Numbers wider than one word are handled one word per cycle, lowest word first:

- The lowest word writes the flag without reading it.
- Interior words read the flag and write it.
- The top word reads the flag and leaves it alone.

Top module: `addsub_unit`

## Requirements
- R1: With `op`=0 (add) and `use_carry`=0, `result` equals (`a` + `b`) mod 2^WIDTH.
- R2: With `op`=1 (subtract) and `use_carry`=0, `result` equals `a` + ~`b` + 1 mod 2^WIDTH, that is `a` − `b`.
- R3: `carry_out` is the carry leaving the most significant bit position. `uns_ovf` equals `carry_out` for add and the inverse of `carry_out` (a borrow) for subtract.
- R4: `sgn_ovf` is 1 exactly when the two numbers actually added (`a` and `b` for add, `a` and ~`b` for subtract) have equal sign bits and the result's sign bit differs. An add of operands with different signs never sets it.
- R5: `negative` equals bit WIDTH−1 of `result`, and `zero` is 1 exactly when every bit of `result` is 0.
- R6: With `use_carry`=1, the stored carry flag is the carry into bit 0 for both operations. For subtract, a stored 1 means "no borrow", so `a` + ~`b` + flag is formed.
- R7: On a rising edge with `set_carry`=1 and `rst`=0, the flag takes the value of `carry_out`. With `set_carry`=0 it keeps its value. The flag is visible on `carry_flag`.
- R8: A synchronous active-high `rst` clears the flag to 0 on the rising edge. An add with `use_carry`=1 right after reset then adds 0.
- R9: At WIDTH=16, 0x7654 + 0x1abc gives 0x9110 with `carry_out`=0 and `sgn_ovf`=1. 0x7654 + 0xffed gives 0x7641 with `carry_out`=1 and `sgn_ovf`=0.
- R10: A three-word sequence gives the full-width sum or difference across the words. The lowest word uses `set_carry`=1 with `use_carry`=0, the middle word uses both set to 1, and the top word uses `use_carry`=1 with `set_carry`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flag updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the carry flag |
| op | input | 1 | 0 = add, 1 = subtract |
| use_carry | input | 1 | 1 = stored flag is the low carry-in |
| set_carry | input | 1 | 1 = write carry-out into the flag at the clock edge |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit |
| uns_ovf | output | 1 | Unsigned overflow (carry for add, borrow for subtract) |
| sgn_ovf | output | 1 | Two's complement overflow |
| negative | output | 1 | Top bit of result |
| zero | output | 1 | Result is all zeros |
| carry_flag | output | 1 | Current stored carry flag |

## Verification
The only internal state is the carry flag. A wrong value in it shows up in the same cycle on `carry_flag`. It also shows up as an off-by-one `result` on the very next operation that has `use_carry` set. A chain that leaves a stale flag after a read-only word, or that misses a write, is caught on the following word of a multi-word sequence. The bench walks such sequences in both directions and with reset placed between them, and compares the flag on every clock.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

    typedef struct packed {
        logic carry;
        logic s;
    } half_sum_t;

    typedef struct packed {
        logic carry;
        logic uns_ovf;
        logic sgn_ovf;
        logic neg;
        logic zero;
    } addsub_flags_t;

    function automatic half_sum_t half_add(input logic x, input logic y);
        half_sum_t r;
        r.s     = x ^ y;
        r.carry = x & y;
        return r;
    endfunction

endpackage

// File: rtl/addsub_full_adder.sv
module addsub_full_adder
    import addsub_pkg::*;
(
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    half_sum_t first;
    half_sum_t second;

    always_comb begin
        first  = half_add(x, y);
        second = half_add(first.s, cin);
        s      = second.s;
        cout   = first.carry | second.carry;
    end
endmodule

// File: rtl/addsub_operand.sv
module addsub_operand
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  addsub_op_e        op,
    input  logic              use_carry,
    input  logic              stored_carry,
    input  logic [WIDTH-1:0]  b_in,
    output logic [WIDTH-1:0]  b_eff,
    output logic              low_cin
);
    logic [WIDTH-1:0] inv_mask;

    assign inv_mask = {WIDTH{op == OP_SUB}};

    always_comb begin
        b_eff = b_in ^ inv_mask;
        if (use_carry) begin
            low_cin = stored_carry;
        end else begin
            low_cin = (op == OP_SUB);
        end
    end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] s,
    output logic             cout
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        addsub_full_adder u_fa (
            .x    (x[i]),
            .y    (y[i]),
            .cin  (chain[i]),
            .s    (s[i]),
            .cout (chain[i+1])
        );
    end

    assign cout = chain[WIDTH];

    // R1 R2: chain output agrees with arithmetic sum of its inputs
    always_comb begin
        p_ripple_sum_r1: assert ({cout, s} == ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}));
    end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  addsub_op_e       op,
    input  logic             a_top,
    input  logic             b_top,
    input  logic [WIDTH-1:0] sum,
    input  logic             cout,
    output addsub_flags_t    flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.carry   = cout;
        flags.uns_ovf = (op == OP_SUB) ? ~cout : cout;
        flags.sgn_ovf = (a_top == b_top) && (sum[MSB] != a_top);
        flags.neg     = sum[MSB];
        flags.zero    = ~|sum;
    end
endmodule

// File: rtl/addsub_carry_reg.sv
module addsub_carry_reg (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (load) begin
            q <= d;
        end
    end

    p_flag_reset_r8: assert property (@(posedge clk) rst |=> (q == 1'b0));
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> (q == $past(q)));
    p_flag_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op,
    input  logic             use_carry,
    input  logic             set_carry,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             uns_ovf,
    output logic             sgn_ovf,
    output logic             negative,
    output logic             zero,
    output logic             carry_flag
);
    localparam int MSB = WIDTH - 1;

    addsub_op_e       op_sel;
    logic [WIDTH-1:0] b_eff;
    logic             low_cin;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             stored;
    addsub_flags_t    flg;

    assign op_sel = addsub_op_e'(op);

    addsub_operand #(.WIDTH(WIDTH)) u_operand (
        .op           (op_sel),
        .use_carry    (use_carry),
        .stored_carry (stored),
        .b_in         (b),
        .b_eff        (b_eff),
        .low_cin      (low_cin)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_ripple (
        .x    (a),
        .y    (b_eff),
        .cin  (low_cin),
        .s    (sum),
        .cout (cout)
    );

    addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .op    (op_sel),
        .a_top (a[MSB]),
        .b_top (b_eff[MSB]),
        .sum   (sum),
        .cout  (cout),
        .flags (flg)
    );

    addsub_carry_reg u_carry (
        .clk  (clk),
        .rst  (rst),
        .load (set_carry),
        .d    (flg.carry),
        .q    (stored)
    );

    assign result     = sum;
    assign carry_out  = flg.carry;
    assign uns_ovf    = flg.uns_ovf;
    assign sgn_ovf    = flg.sgn_ovf;
    assign negative   = flg.neg;
    assign zero       = flg.zero;
    assign carry_flag = stored;

    p_sovf_sign_r4: assert property (@(posedge clk) disable iff (rst)
        sgn_ovf |-> (result[MSB] != a[MSB]));
    p_mixed_no_ovf_r4: assert property (@(posedge clk) disable iff (rst)
        (!op && (a[MSB] != b[MSB])) |-> !sgn_ovf);
    p_zero_neg_r5: assert property (@(posedge clk) disable iff (rst)
        zero |-> !negative);
    p_sub_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        op |-> (uns_ovf != carry_out));
endmodule

// File: tb/addsub_unit_bench.sv
`timescale 1ns/1ps
module addsub_unit_bench;
    localparam int W = 16;
    localparam longint MASK = (64'd1 << W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op = 1'b0, use_carry = 1'b0, set_carry = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [W-1:0] result;
    logic carry_out, uns_ovf, sgn_ovf, negative, zero, carry_flag;

    int checks = 0;
    int errors = 0;
    bit model_carry = 1'b0;
    bit finished = 1'b0;
    longint words[$];

    always #4 clk = ~clk;

    addsub_unit #(.WIDTH(W)) u_addsub_unit (
        .clk(clk), .rst(rst), .op(op), .use_carry(use_carry), .set_carry(set_carry),
        .a(a), .b(b), .result(result), .carry_out(carry_out), .uns_ovf(uns_ovf),
        .sgn_ovf(sgn_ovf), .negative(negative), .zero(zero), .carry_flag(carry_flag)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One operation: drive after falling edge, compare, then clock it in.
    task automatic step(input bit o, input bit uc, input bit sc, input bit r,
                        input longint av, input longint bv, input string tag);
        longint bb, tot, res;
        bit cin, co, ao, bo;
        @(negedge clk);
        chk({tag, " R7 stored flag"}, carry_flag, model_carry);
        op = o; use_carry = uc; set_carry = sc; rst = r;
        a = av[W-1:0]; b = bv[W-1:0];
        #1;
        bb  = o ? (~bv & MASK) : (bv & MASK);
        cin = uc ? model_carry : o;
        tot = (av & MASK) + bb + cin;
        res = tot & MASK;
        co  = tot[W];
        ao  = av[W-1];
        bo  = bb[W-1];
        words.push_back(res);
        chk({tag, o ? " R2 result" : " R1 result"}, result, res);
        chk({tag, " R3 carry_out"}, carry_out, co);
        chk({tag, " R3 uns_ovf"}, uns_ovf, o ? !co : co);
        chk({tag, " R4 sgn_ovf"}, sgn_ovf, (ao == bo) && (res[W-1] != ao));
        chk({tag, " R5 negative"}, negative, res[W-1]);
        chk({tag, " R5 zero"}, zero, res == 0);
        @(posedge clk);
        if (r) model_carry = 1'b0;
        else if (sc) model_carry = co;
    endtask

    task automatic wide(input bit o, input longint x, input longint y, input string tag);
        longint expw;
        words.delete();
        step(o, 0, 1, 0, x, y, {tag, " R10 w0"});
        step(o, 1, 1, 0, x >> W, y >> W, {tag, " R10 w1"});
        step(o, 1, 0, 0, x >> (2*W), y >> (2*W), {tag, " R10 w2"});
        expw = (o ? (x - y) : (x + y)) & ((64'd1 << (3*W)) - 1);
        chk({tag, " R10 wide"}, (words[2] << (2*W)) | (words[1] << W) | words[0], expw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(0, 0, 0, 1, 0, 0, "reset R8");
        // R9 worked examples
        step(0, 0, 1, 0, 'h7654, 'h1abc, "R9 a");
        chk("R9 a value", words[$], 'h9110);
        step(0, 0, 1, 0, 'h7654, 'hffed, "R9 b");
        chk("R9 b value", words[$], 'h7641);
        // flag now 1: use-only add adds 1, flag unchanged (R6, R7)
        step(0, 1, 0, 0, 'h0010, 'h0001, "R6 use add");
        chk("R6 use add value", words[$], 'h0012);
        step(1, 1, 0, 0, 'h0010, 'h0001, "R6 use sub");
        chk("R6 no-borrow value", words[$], 'h000f);
        // reset then use carry adds 0 (R8)
        step(0, 0, 0, 1, 'hffff, 'h0001, "R8 rst");
        step(0, 1, 0, 0, 'h0005, 'h0003, "R8 after");
        chk("R8 after value", words[$], 'h0008);
        // subtract boundaries
        step(1, 0, 1, 0, 'h0000, 'h0001, "R2 borrow");
        step(1, 0, 1, 0, 'h8000, 'h0001, "R4 sub ovf");
        step(1, 0, 0, 0, 'h1234, 'h1234, "R5 zero");
        step(0, 0, 0, 0, 'h7fff, 'h8000, "R4 mixed");
        // multi-word chains
        wide(0, 64'h0000_ffff_ffff_ffff, 64'h0000_0000_0000_0001, "add ripple");
        wide(1, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, "sub borrow");
        wide(0, 64'h0000_1234_5678_9abc, 64'h0000_fedc_ba98_7654, "add mix");
        wide(1, 64'h0000_0000_0000_0014, 64'h0000_0000_0000_0015, "sub neg");
        // random patterns across all variants
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[0], rv[1], rv[2], (rv[7:3] == 0), $urandom, $urandom, "rand R1 R6 R7");
        end
        @(negedge clk);
        chk("final R7 stored flag", carry_flag, model_carry);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule